// File: doc/BRIEF.md
# Supervisory CPU Reset Controller

This block merges three independent fault sources into one CPU reset line. A supply-droop flag comes from an external comparator. A free-running watchdog counter overflows when software stops servicing it. A fault flag comes from an external clock checker, and it only matters while the CPU runs from the external clock. Every source produces the same reset. The reset is then stretched by a fixed number of system-clock cycles, so the CPU restarts only after the supply or fault has been quiet for that long.

The block also owns two configuration bits. One selects which droop level the external comparator uses. The other enables the watchdog. Software services the watchdog by reading its address, which the block sees as a one-cycle strobe. A small cause register records which sources fired when the last reset began, so software can read it after release.

All inputs are taken as synchronous to `clk`. `por_n` is the asynchronous power-on reset. It starts the same stretch as any other source.

Top module: `sup_reset_ctrl`

## Requirements
- R1: `bo_level_sel_o` reflects the threshold bit: 1 selects the lower droop level and 0 the higher one. `cfg_wr` loads it from `cfg_thr_sel` while reset is deasserted.
- R2: The threshold bit is 1 after power-on reset and is forced to 1 on every clock edge at which `cpu_rst_o` is high.
- R3: `cpu_rst_o` rises at the first clock edge that samples any active source: `brownout_i`, a watchdog overflow, or a qualified clock fault. It is high immediately while `por_n` is low.
- R4: `cpu_rst_o` falls exactly STRETCH_CYCLES clock edges after the last edge that sampled an active source (or after `por_n` rises). A new source during the stretch restarts the full count.
- R5: The watchdog counter advances only while its enable bit is 1. With the bit at 0, no watchdog reset ever occurs.
- R6: With the watchdog enabled, an overflow occurs on the 2^WDT_WIDTH-th advancing edge and asserts reset.
- R7: A `wdt_rd_i` strobe clears the watchdog counter, so a full 2^WDT_WIDTH enabled edges must follow before the next overflow.
- R8: `clk_fault_i` causes reset only when `ext_clk_sel_i` is 1. Otherwise it is ignored.
- R9: While reset is asserted, the watchdog counter and its enable bit are cleared and `cfg_wr` is ignored.
- R10: `cause_o` holds bit 0 = droop, bit 1 = watchdog and bit 2 = clock fault. These are captured at the edge where reset starts from the deasserted state and are held until the next such edge. It reads 000 after power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| brownout_i | input | 1 | Comparator flag: supply below selected level |
| bo_level_sel_o | output | 1 | Droop level select to comparator (1 = low level) |
| wdt_rd_i | input | 1 | One-cycle read strobe of the watchdog address |
| clk_fault_i | input | 1 | External clock checker fault flag |
| ext_clk_sel_i | input | 1 | Clock configuration: external clock in use |
| cfg_wr | input | 1 | Write strobe for the configuration bits |
| cfg_thr_sel | input | 1 | Threshold bit value written by `cfg_wr` |
| cfg_wdt_en | input | 1 | Watchdog enable value written by `cfg_wr` |
| cpu_rst_o | output | 1 | CPU reset, active high |
| cause_o | output | 3 | Sources that started the last reset |

## Verification
The bench checks the exact overflow edge of the watchdog both from enable and after a read strobe. A counter that is off by one, or that ignores the strobe, moves the reset by a cycle or fires early. It retriggers the droop flag in the middle of a stretch. A design that fails to reload the count would release the CPU too soon. A clock fault with the external clock deselected must leave reset low, and a configuration write during reset must not survive release. A design that latches such a write leaves the threshold wrong or starts a watchdog nobody enabled. Source combinations from a vector table confirm that the cause bits are captured only on entry and are never overwritten while reset is held.

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int STRETCH_CYCLES = 300000,
  parameter int WDT_WIDTH      = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       brownout_i,
  output logic       bo_level_sel_o,
  input  logic       wdt_rd_i,
  input  logic       clk_fault_i,
  input  logic       ext_clk_sel_i,
  input  logic       cfg_wr,
  input  logic       cfg_thr_sel,
  input  logic       cfg_wdt_en,
  output logic       cpu_rst_o,
  output logic [2:0] cause_o
);

  localparam int CW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_INIT = CW'(STRETCH_CYCLES);

  logic [CW-1:0]        hold_cnt;
  logic [WDT_WIDTH-1:0] wdt_cnt;
  logic                 wdt_en;
  logic                 thr_sel;

  wire clk_trip = clk_fault_i & ext_clk_sel_i;
  wire wdt_ovf  = wdt_en & (&wdt_cnt) & ~wdt_rd_i;
  wire trig     = brownout_i | wdt_ovf | clk_trip;

  assign cpu_rst_o      = hold_cnt != '0;
  assign bo_level_sel_o = thr_sel;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             hold_cnt <= HOLD_INIT;
    else if (trig)          hold_cnt <= HOLD_INIT;
    else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      thr_sel <= 1'b1;
      wdt_en  <= 1'b0;
    end else if (cpu_rst_o) begin
      thr_sel <= 1'b1;
      wdt_en  <= 1'b0;
    end else if (cfg_wr) begin
      thr_sel <= cfg_thr_sel;
      wdt_en  <= cfg_wdt_en;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     wdt_cnt <= '0;
    else if (cpu_rst_o || wdt_rd_i) wdt_cnt <= '0;
    else if (wdt_en)                wdt_cnt <= wdt_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                   cause_o <= 3'b000;
    else if (trig && !cpu_rst_o)  cause_o <= {clk_trip, wdt_ovf, brownout_i};
  end

  AST_THR_FORCED: assert property (@(posedge clk) disable iff (!por_n)
    cpu_rst_o |=> bo_level_sel_o); // R2

  AST_RST_ON_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
    trig |=> cpu_rst_o); // R3

  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    $fell(cpu_rst_o) |-> !$past(trig)); // R4

  AST_WDT_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    (!wdt_en && !wdt_rd_i && !cpu_rst_o) |=> $stable(wdt_cnt)); // R5

  AST_WDT_SERVICE: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rd_i |=> (wdt_cnt == '0)); // R7

  AST_CLK_MASKED: assert property (@(posedge clk) disable iff (!por_n)
    (!ext_clk_sel_i && !brownout_i && !wdt_ovf && !cpu_rst_o) |=> !cpu_rst_o); // R8

  AST_WDT_CLEARED: assert property (@(posedge clk) disable iff (!por_n)
    cpu_rst_o |=> (wdt_cnt == '0 && !wdt_en)); // R9

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_rst_o || !trig) |=> $stable(cause_o)); // R10

endmodule

// File: tb/sup_reset_ctrl_tb_top.sv
module sup_reset_ctrl_tb_top;
  localparam int STRETCH = 8;
  localparam int WW      = 4;
  localparam int WDT_N   = 1 << WW;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic brownout_i = 1'b0, wdt_rd_i = 1'b0, clk_fault_i = 1'b0, ext_clk_sel_i = 1'b0;
  logic cfg_wr = 1'b0, cfg_thr_sel = 1'b1, cfg_wdt_en = 1'b0;
  logic bo_level_sel_o, cpu_rst_o;
  logic [2:0] cause_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [2:0] last_cause;

  always #2.5 clk = ~clk;

  sup_reset_ctrl #(.STRETCH_CYCLES(STRETCH), .WDT_WIDTH(WW)) dut_i (
    .clk(clk), .por_n(por_n), .brownout_i(brownout_i), .bo_level_sel_o(bo_level_sel_o),
    .wdt_rd_i(wdt_rd_i), .clk_fault_i(clk_fault_i), .ext_clk_sel_i(ext_clk_sel_i),
    .cfg_wr(cfg_wr), .cfg_thr_sel(cfg_thr_sel), .cfg_wdt_en(cfg_wdt_en),
    .cpu_rst_o(cpu_rst_o), .cause_o(cause_o));

  // {droop, clk_fault, ext_sel} | expected reset | expected cause
  localparam logic [6:0] VEC [8] = '{
    7'b000_0_000, 7'b001_0_000, 7'b010_0_000, 7'b011_1_100,
    7'b100_1_001, 7'b101_1_001, 7'b110_1_001, 7'b111_1_101 };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    check("R3 reset during por", cpu_rst_o, 1);
    step(2);
    por_n = 1'b1;
    step(STRETCH - 1);
    check("R4 still held after por", cpu_rst_o, 1);
    step(1);
    check("R4 released after por", cpu_rst_o, 0);
    check("R10 cause after por", cause_o, 3'b000);
    check("R2 threshold after por", bo_level_sel_o, 1);
    last_cause = 3'b000;

    for (int i = 0; i < 8; i++) begin
      {brownout_i, clk_fault_i, ext_clk_sel_i} = VEC[i][6:4];
      step(1);
      brownout_i = 0; clk_fault_i = 0; ext_clk_sel_i = 0;
      check("R3/R8 table reset", cpu_rst_o, VEC[i][3]);
      if (VEC[i][3]) begin
        last_cause = VEC[i][2:0];
        check("R10 table cause", cause_o, last_cause);
        step(STRETCH);
        check("R4 table release", cpu_rst_o, 0);
      end else begin
        check("R10 table cause kept", cause_o, last_cause);
      end
    end

    // R8 long clock fault without external clock selected
    clk_fault_i = 1; ext_clk_sel_i = 0;
    step(30);
    check("R8 masked fault", cpu_rst_o, 0);
    clk_fault_i = 0;

    // R1 threshold write
    cfg_wr = 1; cfg_thr_sel = 0; cfg_wdt_en = 0;
    step(1);
    cfg_wr = 0;
    check("R1 threshold high level", bo_level_sel_o, 0);
    step(WDT_N + 10);
    check("R5 disabled watchdog silent", cpu_rst_o, 0);

    // R6 watchdog overflow from enable
    cfg_wr = 1; cfg_thr_sel = 0; cfg_wdt_en = 1;
    step(1);
    cfg_wr = 0;
    step(WDT_N - 1);
    check("R6 before overflow", cpu_rst_o, 0);
    step(1);
    check("R6 overflow reset", cpu_rst_o, 1);
    check("R10 watchdog cause", cause_o, 3'b010);
    step(STRETCH);
    check("R4 release after watchdog", cpu_rst_o, 0);
    check("R2 threshold restored", bo_level_sel_o, 1);
    step(WDT_N + 4);
    check("R9 enable cleared by reset", cpu_rst_o, 0);

    // R7 service by read strobe
    cfg_wr = 1; cfg_thr_sel = 1; cfg_wdt_en = 1;
    step(1);
    cfg_wr = 0;
    step(10);
    wdt_rd_i = 1;
    step(1);
    wdt_rd_i = 0;
    step(WDT_N - 1);
    check("R7 serviced no reset", cpu_rst_o, 0);
    step(1);
    check("R7 overflow after service", cpu_rst_o, 1);
    step(STRETCH);
    check("R4 release after service test", cpu_rst_o, 0);

    // R9 writes ignored during reset
    brownout_i = 1;
    step(1);
    brownout_i = 0;
    cfg_wr = 1; cfg_thr_sel = 0; cfg_wdt_en = 1;
    step(1);
    cfg_wr = 0;
    step(STRETCH - 2);
    check("R4 held before release", cpu_rst_o, 1);
    step(1);
    check("R4 release after droop", cpu_rst_o, 0);
    check("R9 threshold write ignored", bo_level_sel_o, 1);
    step(WDT_N + 4);
    check("R9 enable write ignored", cpu_rst_o, 0);

    // R4 restart of stretch by second droop
    brownout_i = 1;
    step(1);
    brownout_i = 0;
    step(4);
    brownout_i = 1;
    step(1);
    brownout_i = 0;
    step(STRETCH - 1);
    check("R4 restarted stretch held", cpu_rst_o, 1);
    check("R10 cause from first entry", cause_o, 3'b001);
    step(1);
    check("R4 restarted stretch release", cpu_rst_o, 0);

    finish_run();
  end
endmodule